// File: doc/BRIEF.md
# I2C Slave Register Access Engine

This block is the serial-bus front end of a small four-register port expander. It takes the raw clock and data lines of an I2C bus, brings them into the system clock domain through two-flop synchronizers, and watches them for START, repeated START and STOP conditions. It answers to a 7-bit address whose top four bits are fixed and whose bottom three bits come from board strap pins. The strap pins let eight such expanders share one bus.

A write transfer carries a command byte and then any number of data bytes. The command byte chooses one of four registers, and every later data byte in the same transfer is written to that register through a single-cycle write strobe. The chosen register pointer survives STOP and later transfers. A read transfer streams that register back, MSB first, for as long as the master acknowledges. The register file itself sits outside the block: the engine presents the pointer and samples the file's read data combinationally. The engine pulls the data line low through an open-drain enable and never stretches the clock. At the acknowledge of an accepted read address it raises a one-cycle pulse, which lets neighbouring logic such as change-detect clear.

Top module: `i2c_regport_slave`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal binary 0111 followed by strap bits [2:0] (0x38 to 0x3F). A non-matching address gets no acknowledge, and the rest of that transfer causes no register write and no read pulse.
- R2: Bit 0 of the address byte gives the direction: 0 is a write and 1 is a read.
- R3: In a write transfer, the first byte after the address is the command byte. It is always acknowledged. Its two least significant bits set the pointer (0 input, 1 output, 2 polarity, 3 configuration), and its upper six bits are ignored.
- R4: Each data byte that follows the command byte in the same write transfer is acknowledged. It produces exactly one single-cycle write strobe carrying that byte to the pointed register. The pointer does not advance.
- R5: The pointer keeps its value across STOP and across later transfers. Reads return the pointed register until a new command byte is written.
- R6: After reset, a read address gets no acknowledge until a command byte has been accepted.
- R7: An accepted read sends the pointed register MSB first, and sends it again for every byte the master acknowledges. After a master NACK the data line is released and stays released.
- R8: The read pulse is high for exactly one system clock, once for each accepted read address, and never for a refused one.
- R9: A STOP releases the data line and abandons any partial byte without a write. A START or repeated START at any point restarts address reception.
- R10: The data-line enable changes only while the synchronized clock line is low.
- R11: After reset, the data line is released and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Low three address bits from strap pins |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| reg_ptr_o | output | 2 | Register currently pointed at |
| reg_wr_o | output | 1 | One-cycle write strobe to the pointed register |
| reg_wdata_o | output | 8 | Byte to write |
| reg_rdata_i | input | 8 | Contents of the pointed register |
| rd_open_o | output | 1 | One-cycle pulse at the acknowledge of an accepted read address |

## Verification
The hardest condition to reach is a read that arrives before any command byte has been set. It exists only once per reset, and any earlier random write closes it. The stimulus therefore sends a read address as the very first transfer after reset, before any random traffic. It also breaks bytes off mid-way with STOP and with repeated START, and then checks that the pointer and the register file are untouched while a fully formed transfer that follows still works.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXDONE,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MNEXT,
    ST_WAIT
  } eng_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DATA
  } byte_kind_e;

  typedef struct packed {
    logic scl_lvl;
    logic sda_lvl;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= {W{RST_VAL}};
        end else begin
          if (s == 0) stage_q[s] <= d_i;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_rp_busmon.sv
module i2c_rp_busmon
  import i2c_rp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    ev_o.scl_lvl  = scl_s;
    ev_o.sda_lvl  = sda_s;
    ev_o.scl_rise = scl_s & ~scl_q;
    ev_o.scl_fall = ~scl_s & scl_q;
    ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 7,
  parameter int STRAP_W = 3,
  parameter int PW      = 2,
  parameter logic [AW-STRAP_W-1:0] ADDR_HI = 4'b0111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bus_ev_t            ev_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DW-1:0]      rd_data_i,
  output logic               sda_pull_o,
  output logic [PW-1:0]      ptr_o,
  output logic               wr_o,
  output logic [DW-1:0]      wdata_o,
  output logic               rd_open_o
);

  localparam int CW = $clog2(DW) + 1;

  eng_state_e      state_q, state_n;
  byte_kind_e      kind_q, kind_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [DW-1:0]   sh_q, sh_n;
  logic            is_rd_q, is_rd_n;
  logic [PW-1:0]   ptr_q, ptr_n;
  logic            pvld_q, pvld_n;
  logic            pull_q, pull_n;
  logic            wr_q, wr_n;
  logic [DW-1:0]   wd_q, wd_n;
  logic            rdo_q, rdo_n;

  logic [DW-1:0]   full_byte;
  logic            addr_hit;
  logic            ack_dec;

  assign full_byte = {sh_q[DW-2:0], ev_i.sda_lvl};
  assign addr_hit  = (sh_q[DW-1:1] == {ADDR_HI, strap_i});

  always_comb begin
    if (kind_q == K_ADDR) ack_dec = addr_hit & (~sh_q[0] | pvld_q);
    else                  ack_dec = 1'b1;
  end

  always_comb begin
    state_n = state_q;
    kind_n  = kind_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    is_rd_n = is_rd_q;
    ptr_n   = ptr_q;
    pvld_n  = pvld_q;
    pull_n  = pull_q;
    wr_n    = 1'b0;
    wd_n    = wd_q;
    rdo_n   = 1'b0;

    if (ev_i.stop) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
    end else if (ev_i.start) begin
      state_n = ST_RX;
      kind_n  = K_ADDR;
      cnt_n   = '0;
      pull_n  = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (ev_i.scl_rise) begin
            sh_n  = full_byte;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CW'(DW - 1)) state_n = ST_RXDONE;
          end
        end
        ST_RXDONE: begin
          if (ev_i.scl_fall) begin
            if (ack_dec) begin
              pull_n  = 1'b1;
              state_n = ST_ACK;
              if (kind_q == K_ADDR) is_rd_n = sh_q[0];
            end else begin
              state_n = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (ev_i.scl_rise) begin
            case (kind_q)
              K_ADDR: rdo_n = is_rd_q;
              K_CMD: begin
                ptr_n  = sh_q[PW-1:0];
                pvld_n = 1'b1;
              end
              default: begin
                wr_n = 1'b1;
                wd_n = sh_q;
              end
            endcase
          end
          if (ev_i.scl_fall) begin
            cnt_n = '0;
            if (kind_q == K_ADDR && is_rd_q) begin
              sh_n    = rd_data_i;
              pull_n  = ~rd_data_i[DW-1];
              state_n = ST_TX;
            end else begin
              pull_n  = 1'b0;
              state_n = ST_RX;
              kind_n  = (kind_q == K_ADDR) ? K_CMD : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (ev_i.scl_rise) cnt_n = cnt_q + 1'b1;
          if (ev_i.scl_fall) begin
            if (cnt_q == CW'(DW)) begin
              pull_n  = 1'b0;
              state_n = ST_MACK;
            end else begin
              sh_n   = {sh_q[DW-2:0], 1'b0};
              pull_n = ~sh_q[DW-2];
            end
          end
        end
        ST_MACK: begin
          if (ev_i.scl_rise) state_n = ev_i.sda_lvl ? ST_WAIT : ST_MNEXT;
        end
        ST_MNEXT: begin
          if (ev_i.scl_fall) begin
            cnt_n   = '0;
            sh_n    = rd_data_i;
            pull_n  = ~rd_data_i[DW-1];
            state_n = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      is_rd_q <= 1'b0;
      ptr_q   <= '0;
      pvld_q  <= 1'b0;
      pull_q  <= 1'b0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      rdo_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      is_rd_q <= is_rd_n;
      ptr_q   <= ptr_n;
      pvld_q  <= pvld_n;
      pull_q  <= pull_n;
      wr_q    <= wr_n;
      wd_q    <= wd_n;
      rdo_q   <= rdo_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign ptr_o      = ptr_q;
  assign wr_o       = wr_q;
  assign wdata_o    = wd_q;
  assign rd_open_o  = rdo_q;

  // R10: the pull enable moves only after the clock line was seen low, or on a bus condition
  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> (!$past(ev_i.scl_lvl) || $past(ev_i.start) || $past(ev_i.stop)));

  // R9: a STOP always leaves the data line released
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.stop |=> !pull_q);

  // R4: the write strobe lasts a single cycle
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  // R8: the read pulse lasts a single cycle and only follows a granted pointer
  p_rdopen_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdo_q |=> !rdo_q);
  p_rdopen_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdo_q |-> (pvld_q && is_rd_q));

  // R6: a read address before any command byte is never acknowledged
  p_early_read_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RXDONE && kind_q == K_ADDR && ev_i.scl_fall && !ev_i.start
     && !ev_i.stop && sh_q[0] && !pvld_q) |=> !pull_q);

  // R1: acknowledging an address implies the address matched the straps
  p_addr_ack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pull_q) && state_q == ST_ACK && kind_q == K_ADDR) |-> addr_hit);

  // R5: the pointer only moves at the acknowledge of a command byte
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> ($past(state_q) == ST_ACK && $past(kind_q) == K_CMD));

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2c_rp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 7,
  parameter int STRAP_W     = 3,
  parameter int NREG        = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-STRAP_W-1:0] ADDR_HI = 4'b0111
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [STRAP_W-1:0]      strap_i,
  output logic                    sda_pull_o,
  output logic [$clog2(NREG)-1:0] reg_ptr_o,
  output logic                    reg_wr_o,
  output logic [DW-1:0]           reg_wdata_o,
  input  logic [DW-1:0]           reg_rdata_i,
  output logic                    rd_open_o
);

  localparam int PW = $clog2(NREG);

  logic [1:0] lines_s;
  bus_ev_t    ev;

  i2c_rp_sync #(
    .W       (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  i2c_rp_busmon u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_s (lines_s[1]),
    .sda_s (lines_s[0]),
    .ev_o  (ev)
  );

  i2c_rp_engine #(
    .DW      (DW),
    .AW      (AW),
    .STRAP_W (STRAP_W),
    .PW      (PW),
    .ADDR_HI (ADDR_HI)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev),
    .strap_i    (strap_i),
    .rd_data_i  (reg_rdata_i),
    .sda_pull_o (sda_pull_o),
    .ptr_o      (reg_ptr_o),
    .wr_o       (reg_wr_o),
    .wdata_o    (reg_wdata_o),
    .rd_open_o  (rd_open_o)
  );

  // R4/R8: a write strobe and a read pulse never coincide
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && rd_open_o));

endmodule

// File: tb/sim_i2c_regport_slave.sv
module sim_i2c_regport_slave;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       sda_pull;
  logic [1:0] ptr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rd_open;
  logic       sda_line;

  logic [7:0] regs [4];
  logic [7:0] in_port = 8'h00;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int open_cnt = 0;
  int r10_viol = 0;
  logic prev_pull = 1'b0;

  logic [7:0] m_regs [4];
  logic [1:0] m_ptr = 2'd0;
  bit         m_valid = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;
  assign rdata = (ptr == 2'd0) ? in_port : regs[ptr];

  i2c_regport_slave u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .strap_i     (strap),
    .sda_pull_o  (sda_pull),
    .reg_ptr_o   (ptr),
    .reg_wr_o    (wr),
    .reg_wdata_o (wdata),
    .reg_rdata_i (rdata),
    .rd_open_o   (rd_open)
  );

  always @(posedge clk) if (wr) regs[ptr] <= wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr) wr_cnt++;
      if (rd_open) open_cnt++;
      if (sda_pull != prev_pull && scl_m) r10_viol++;
    end
    prev_pull = sda_pull;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] d, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~mack);
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input bit rd);
    return {a, rd};
  endfunction

  function automatic logic [7:0] expect_read();
    return (m_ptr == 2'd0) ? in_port : m_regs[m_ptr];
  endfunction

  function automatic bit addr_ok(input logic [6:0] a, input bit rd);
    return (a == {4'b0111, strap}) && (!rd || m_valid);
  endfunction

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input int nd);
    bit ack;
    logic [7:0] d;
    int w0;
    bit exp_ack;
    w0 = wr_cnt;
    exp_ack = addr_ok(a, 1'b0);
    bus_start();
    put_byte(addr_byte(a, 1'b0), ack);
    chk(ack == exp_ack, "R1 write address ack", ack, exp_ack);
    if (ack) begin
      put_byte(cmd, ack);
      chk(ack, "R3 command ack", ack, 1);
      m_ptr = cmd[1:0];
      m_valid = 1'b1;
      for (int i = 0; i < nd; i++) begin
        d = 8'($urandom);
        put_byte(d, ack);
        chk(ack, "R4 data ack", ack, 1);
        m_regs[m_ptr] = d;
      end
    end
    bus_stop();
    chk(ptr == m_ptr, "R3 pointer value", ptr, m_ptr);
    chk(wr_cnt - w0 == (exp_ack ? nd : 0), "R4 write strobe count", wr_cnt - w0, exp_ack ? nd : 0);
    if (exp_ack && nd > 0)
      chk(regs[m_ptr] == m_regs[m_ptr], "R4 register content", regs[m_ptr], m_regs[m_ptr]);
  endtask

  task automatic do_read(input logic [6:0] a, input int nb, input bit restart);
    bit ack;
    bit exp_ack;
    logic [7:0] d;
    int o0;
    o0 = open_cnt;
    if (!restart) bus_start();
    else bus_start();
    exp_ack = addr_ok(a, 1'b1);
    put_byte(addr_byte(a, 1'b1), ack);
    chk(ack == exp_ack, "R6 read address ack", ack, exp_ack);
    if (ack) begin
      for (int i = 0; i < nb; i++) begin
        get_byte(d, i != nb - 1);
        chk(d == expect_read(), "R7 read byte", d, expect_read());
      end
      chk(sda_pull == 1'b0, "R7 released after NACK", sda_pull, 0);
    end
    bus_stop();
    chk(open_cnt - o0 == (exp_ack ? 1 : 0), "R8 read pulse count", open_cnt - o0, exp_ack ? 1 : 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int w0;
    process::self().srandom(32'd1234);
    for (int i = 0; i < 4; i++) begin
      regs[i] = 8'h00;
      m_regs[i] = 8'h00;
    end
    strap = 3'b101;
    in_port = 8'hC3;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk(sda_pull == 1'b0, "R11 reset release", sda_pull, 0);
    chk(wr == 1'b0 && rd_open == 1'b0, "R11 reset strobes", {wr, rd_open}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6: read before any command byte is refused
    do_read({4'b0111, strap}, 1, 1'b0);

    // R1: wrong address write, bytes after it are ignored
    w0 = wr_cnt;
    bus_start();
    put_byte(addr_byte(7'h3A, 1'b0), ack);
    chk(!ack, "R1 foreign address nack", ack, 0);
    put_byte(8'h01, ack);
    put_byte(8'h77, ack);
    bus_stop();
    chk(wr_cnt == w0, "R1 no write after foreign address", wr_cnt - w0, 0);

    // R3/R4: upper command bits ignored, same register rewritten
    do_write({4'b0111, strap}, 8'hFD, 2);
    do_write({4'b0111, strap}, 8'h02, 3);

    // R5/R2: pointer persists, read in a separate transfer
    do_read({4'b0111, strap}, 3, 1'b0);
    do_read({4'b0111, strap}, 2, 1'b0);

    // R7: input register read via repeated START
    bus_start();
    put_byte(addr_byte({4'b0111, strap}, 1'b0), ack);
    put_byte(8'h00, ack);
    m_ptr = 2'd0;
    do_read({4'b0111, strap}, 2, 1'b1);
    chk(ptr == 2'd0, "R5 pointer after repeated start", ptr, 0);

    // R9: STOP in the middle of a data byte aborts it
    w0 = wr_cnt;
    bus_start();
    put_byte(addr_byte({4'b0111, strap}, 1'b0), ack);
    put_byte(8'h03, ack);
    m_ptr = 2'd3;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    chk(wr_cnt == w0, "R9 partial byte not written", wr_cnt - w0, 0);
    chk(sda_pull == 1'b0, "R9 released after stop", sda_pull, 0);

    // R9: repeated START mid-byte restarts address reception
    bus_start();
    put_byte(addr_byte({4'b0111, strap}, 1'b0), ack);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    do_read({4'b0111, strap}, 1, 1'b1);
    chk(regs[3] == m_regs[3], "R9 register untouched", regs[3], m_regs[3]);

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [6:0] a;
      int op;
      strap = 3'($urandom);
      in_port = 8'($urandom);
      if (($urandom % 4) != 0) a = {4'b0111, strap};
      else begin
        a = 7'($urandom);
        if (a == {4'b0111, strap}) a = a ^ 7'h40;
      end
      op = $urandom % 3;
      if (op == 0) do_write(a, 8'($urandom), $urandom % 4);
      else if (op == 1) do_read(a, 1 + $urandom % 3, 1'b0);
      else begin
        do_write(a, 8'($urandom), 0);
        do_read(a, 1 + $urandom % 2, 1'b0);
      end
    end

    chk(r10_viol == 0, "R10 pull changes with clock low", r10_viol, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule